// File: doc/BRIEF.md
# Register Alias Table Renamer

This block renames a group of up to four micro-operations in every clock cycle. Each operation names two architectural source registers and one architectural destination. A small map holds one entry per architectural register. The entry says whether the newest value of that register is already in the architectural register file or is still owed by a particular reorder-buffer slot. Sources are translated through this map. Each destination is bound to the buffer slot that arrives with the group, and the map is updated so that every later reader finds that slot.

Inside one group, a source that names the destination of an earlier valid lane is bound to that lane's new slot. It does not take the stale map entry. For each source the block returns four things: an in-flight flag, a tag, an operand value and a ready flag. The tag is a slot index when the source is in flight, and the register number when it is not. The value comes from the architectural file for an unmapped source. For a mapped source it comes from the buffer's data array, provided that slot's completion flag is set.

A retiring slot returns its register to the architectural file, but only if the map still points at that same slot. A flush clears every mapping in one cycle.

Top module: `alias_renamer`

## Requirements
- R1: After reset every register is unmapped. An unmapped source reports in-flight 0, its tag is the register number (zero-extended), its value is the architectural file entry for that register, and ready is 1.
- R2: A source whose register is mapped in the table reports in-flight 1 and the mapped slot index as its tag.
- R3: For a source mapped in the table, a set completion flag gives the value from the slot's data and ready 1. A clear flag gives value 0 and ready 0. A source that is not in flight is always ready.
- R4: A valid lane's destination is mapped to that lane's slot from the next cycle on. When several valid lanes in one group write the same register, the highest-numbered of them wins.
- R5: A source in lane k that matches the destination of a valid lane j<k takes the slot of the nearest such lane, with in-flight 1, value 0 and ready 0. Invalid lanes neither forward nor update the table.
- R6: A retire whose slot matches the table entry of its register returns that register to the architectural file on the next cycle.
- R7: A retire whose slot does not match the current table entry leaves that entry unchanged.
- R8: A rename and a retire that touch the same register in the same cycle leave the rename's mapping in place.
- R9: A flush clears every mapping on the next cycle. A rename group presented in the same cycle is discarded.
- R10: Source lookup uses the table as it stood at the start of the cycle. A retire or flush in the same cycle does not alter that cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Clear all mappings |
| ren_valid_i | input | LANES | Per-lane valid for the rename group |
| ren_src_a_i | input | LANES*REG_W | First source register per lane |
| ren_src_b_i | input | LANES*REG_W | Second source register per lane |
| ren_dst_i | input | LANES*REG_W | Destination register per lane |
| ren_slot_i | input | LANES*TAG_W | Newly allocated buffer slot per lane |
| ret_valid_i | input | 1 | A buffer slot retires this cycle |
| ret_arch_i | input | REG_W | Destination register of the retiring slot |
| ret_slot_i | input | TAG_W | Index of the retiring slot |
| arf_data_i | input | ARCH_REGS*DATA_W | Architectural file values, register r at bits r*DATA_W |
| slot_data_i | input | SLOTS*DATA_W | Buffer result values, slot s at bits s*DATA_W |
| slot_done_i | input | SLOTS | Per-slot result-valid flag |
| opa_inflight_o | output | LANES | First source is owed by a buffer slot |
| opa_tag_o | output | LANES*TAG_W | First source tag |
| opa_data_o | output | LANES*DATA_W | First source value |
| opa_ready_o | output | LANES | First source value is available |
| opb_inflight_o | output | LANES | Second source is owed by a buffer slot |
| opb_tag_o | output | LANES*TAG_W | Second source tag |
| opb_data_o | output | LANES*DATA_W | Second source value |
| opb_ready_o | output | LANES | Second source value is available |

## Verification
The directed groups start with a two-operation chain in which one register is remapped by lane 0 and read back by lane 1. This separates forwarding within the group from a table read. A group in which several lanes, one of them invalid, write the same register shows whether the highest valid lane wins and whether invalid lanes are ignored. Retires with matching and with stale slots, a retire that collides with a rename, and a flush that arrives together with a group separate the priority rules between rename, retire and flush. It also shows that the outputs in that cycle still reflect the old table. A long random phase with mixed completion flags then compares every source of every lane against a behavioural map model in every cycle.

// File: rtl/alias_pkg.sv
// Shared definitions for the alias renamer.
// Assumes nothing beyond standard SystemVerilog.
package alias_pkg;
    // Where a translated source finds its newest producer.
    typedef enum logic [1:0] {
        SRC_ARCH  = 2'd0,   // architectural file holds the value
        SRC_TABLE = 2'd1,   // mapped slot from the table
        SRC_GROUP = 2'd2    // slot allocated by an earlier lane this cycle
    } src_origin_e;
endpackage

// File: rtl/alias_map_table.sv
// Per-register map state: in-flight flag plus producing slot.
// Assumes ARCH_REGS is a power of two so every register index is in range.
// Update priority, lowest to highest: retire, rename lanes in order, flush.
module alias_map_table #(
    parameter int ARCH_REGS = 8,
    parameter int SLOTS     = 40,
    parameter int LANES     = 4,
    localparam int REG_W    = $clog2(ARCH_REGS),
    localparam int TAG_W    = $clog2(SLOTS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  flush_i,
    input  logic [LANES-1:0]                      wr_valid_i,
    input  logic [LANES-1:0][REG_W-1:0]           wr_arch_i,
    input  logic [LANES-1:0][TAG_W-1:0]           wr_slot_i,
    input  logic                                  ret_valid_i,
    input  logic [REG_W-1:0]                      ret_arch_i,
    input  logic [TAG_W-1:0]                      ret_slot_i,
    output logic [ARCH_REGS-1:0]                  map_inflight_o,
    output logic [ARCH_REGS-1:0][TAG_W-1:0]       map_slot_o
);
    logic [ARCH_REGS-1:0]            infl_q, infl_d;
    logic [ARCH_REGS-1:0][TAG_W-1:0] slot_q, slot_d;

    // Next-state: retire if still latest writer, then lane writes, then flush.
    always_comb begin
        infl_d = infl_q;
        slot_d = slot_q;
        if (ret_valid_i && infl_q[ret_arch_i] && (slot_q[ret_arch_i] == ret_slot_i))
            infl_d[ret_arch_i] = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (wr_valid_i[l]) begin
                infl_d[wr_arch_i[l]] = 1'b1;
                slot_d[wr_arch_i[l]] = wr_slot_i[l];
            end
        end
        if (flush_i)
            infl_d = '0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            infl_q <= '0;
            slot_q <= '0;
        end else begin
            infl_q <= infl_d;
            slot_q <= slot_d;
        end
    end

    assign map_inflight_o = infl_q;
    assign map_slot_o     = slot_q;
endmodule

// File: rtl/alias_src_xlate.sv
// Translates one source register of lane LANE through the table and
// through the destinations of lanes below it in the same group.
// Assumes SLOTS needs at least as many tag bits as ARCH_REGS needs register bits.
module alias_src_xlate
    import alias_pkg::*;
#(
    parameter int ARCH_REGS = 8,
    parameter int SLOTS     = 40,
    parameter int LANES     = 4,
    parameter int LANE      = 0,
    localparam int REG_W    = $clog2(ARCH_REGS),
    localparam int TAG_W    = $clog2(SLOTS)
) (
    input  logic [REG_W-1:0]                 src_i,
    input  logic [ARCH_REGS-1:0]             map_inflight_i,
    input  logic [ARCH_REGS-1:0][TAG_W-1:0]  map_slot_i,
    input  logic [LANES-1:0]                 grp_valid_i,
    input  logic [LANES-1:0][REG_W-1:0]      grp_dst_i,
    input  logic [LANES-1:0][TAG_W-1:0]      grp_slot_i,
    output src_origin_e                      origin_o,
    output logic [TAG_W-1:0]                 tag_o
);
    // Table lookup first; earlier lanes override, the nearest one last.
    always_comb begin
        origin_o = SRC_ARCH;
        tag_o    = TAG_W'(src_i);
        if (map_inflight_i[src_i]) begin
            origin_o = SRC_TABLE;
            tag_o    = map_slot_i[src_i];
        end
        for (int j = 0; j < LANE; j++) begin
            if (grp_valid_i[j] && (grp_dst_i[j] == src_i)) begin
                origin_o = SRC_GROUP;
                tag_o    = grp_slot_i[j];
            end
        end
    end
endmodule

// File: rtl/alias_operand_fetch.sv
// Picks the operand value and ready flag for one translated source.
// Assumes a slot allocated within the current group has not completed.
module alias_operand_fetch
    import alias_pkg::*;
#(
    parameter int ARCH_REGS = 8,
    parameter int SLOTS     = 40,
    parameter int DATA_W    = 32,
    localparam int REG_W    = $clog2(ARCH_REGS),
    localparam int TAG_W    = $clog2(SLOTS)
) (
    input  src_origin_e                         origin_i,
    input  logic [TAG_W-1:0]                    tag_i,
    input  logic [REG_W-1:0]                    src_i,
    input  logic [ARCH_REGS-1:0][DATA_W-1:0]    arf_data_i,
    input  logic [SLOTS-1:0][DATA_W-1:0]        slot_data_i,
    input  logic [SLOTS-1:0]                    slot_done_i,
    output logic [DATA_W-1:0]                   data_o,
    output logic                                ready_o
);
    // Select value source by origin; completed slots supply data.
    always_comb begin
        data_o  = '0;
        ready_o = 1'b0;
        case (origin_i)
            SRC_ARCH: begin
                data_o  = arf_data_i[src_i];
                ready_o = 1'b1;
            end
            SRC_TABLE: begin
                if (slot_done_i[tag_i]) begin
                    data_o  = slot_data_i[tag_i];
                    ready_o = 1'b1;
                end
            end
            default: begin
                data_o  = '0;
                ready_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alias_renamer.sv
// Top of the renamer: a map table plus, for every lane and both sources,
// a translator and an operand fetch. Outputs are combinational from the
// current inputs and the table as it stood at the start of the cycle.
module alias_renamer
    import alias_pkg::*;
#(
    parameter int ARCH_REGS = 8,
    parameter int SLOTS     = 40,
    parameter int LANES     = 4,
    parameter int DATA_W    = 32,
    localparam int REG_W    = $clog2(ARCH_REGS),
    localparam int TAG_W    = $clog2(SLOTS),
    localparam int NSRC     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic [LANES-1:0]             ren_valid_i,
    input  logic [LANES*REG_W-1:0]       ren_src_a_i,
    input  logic [LANES*REG_W-1:0]       ren_src_b_i,
    input  logic [LANES*REG_W-1:0]       ren_dst_i,
    input  logic [LANES*TAG_W-1:0]       ren_slot_i,
    input  logic                         ret_valid_i,
    input  logic [REG_W-1:0]             ret_arch_i,
    input  logic [TAG_W-1:0]             ret_slot_i,
    input  logic [ARCH_REGS*DATA_W-1:0]  arf_data_i,
    input  logic [SLOTS*DATA_W-1:0]      slot_data_i,
    input  logic [SLOTS-1:0]             slot_done_i,
    output logic [LANES-1:0]             opa_inflight_o,
    output logic [LANES*TAG_W-1:0]       opa_tag_o,
    output logic [LANES*DATA_W-1:0]      opa_data_o,
    output logic [LANES-1:0]             opa_ready_o,
    output logic [LANES-1:0]             opb_inflight_o,
    output logic [LANES*TAG_W-1:0]       opb_tag_o,
    output logic [LANES*DATA_W-1:0]      opb_data_o,
    output logic [LANES-1:0]             opb_ready_o
);
    logic [LANES-1:0][REG_W-1:0]             grp_dst;
    logic [LANES-1:0][TAG_W-1:0]             grp_slot;
    logic [NSRC-1:0][LANES-1:0][REG_W-1:0]   src_reg;
    logic [ARCH_REGS-1:0][DATA_W-1:0]        arf_data;
    logic [SLOTS-1:0][DATA_W-1:0]            slot_data;
    logic [ARCH_REGS-1:0]                    map_inflight;
    logic [ARCH_REGS-1:0][TAG_W-1:0]         map_slot;
    logic [NSRC-1:0][LANES-1:0]              src_infl;
    logic [NSRC-1:0][LANES-1:0][TAG_W-1:0]   src_tag;
    logic [NSRC-1:0][LANES-1:0][DATA_W-1:0]  src_data;
    logic [NSRC-1:0][LANES-1:0]              src_rdy;

    assign grp_dst    = ren_dst_i;
    assign grp_slot   = ren_slot_i;
    assign src_reg[0] = ren_src_a_i;
    assign src_reg[1] = ren_src_b_i;
    assign arf_data   = arf_data_i;
    assign slot_data  = slot_data_i;

    alias_map_table #(
        .ARCH_REGS (ARCH_REGS),
        .SLOTS     (SLOTS),
        .LANES     (LANES)
    ) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_i        (flush_i),
        .wr_valid_i     (ren_valid_i),
        .wr_arch_i      (grp_dst),
        .wr_slot_i      (grp_slot),
        .ret_valid_i    (ret_valid_i),
        .ret_arch_i     (ret_arch_i),
        .ret_slot_i     (ret_slot_i),
        .map_inflight_o (map_inflight),
        .map_slot_o     (map_slot)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            src_origin_e origin;

            alias_src_xlate #(
                .ARCH_REGS (ARCH_REGS),
                .SLOTS     (SLOTS),
                .LANES     (LANES),
                .LANE      (l)
            ) u_xlate (
                .src_i          (src_reg[s][l]),
                .map_inflight_i (map_inflight),
                .map_slot_i     (map_slot),
                .grp_valid_i    (ren_valid_i),
                .grp_dst_i      (grp_dst),
                .grp_slot_i     (grp_slot),
                .origin_o       (origin),
                .tag_o          (src_tag[s][l])
            );

            alias_operand_fetch #(
                .ARCH_REGS (ARCH_REGS),
                .SLOTS     (SLOTS),
                .DATA_W    (DATA_W)
            ) u_fetch (
                .origin_i    (origin),
                .tag_i       (src_tag[s][l]),
                .src_i       (src_reg[s][l]),
                .arf_data_i  (arf_data),
                .slot_data_i (slot_data),
                .slot_done_i (slot_done_i),
                .data_o      (src_data[s][l]),
                .ready_o     (src_rdy[s][l])
            );

            assign src_infl[s][l] = (origin != SRC_ARCH);
        end
    end

    assign opa_inflight_o = src_infl[0];
    assign opa_tag_o      = src_tag[0];
    assign opa_data_o     = src_data[0];
    assign opa_ready_o    = src_rdy[0];
    assign opb_inflight_o = src_infl[1];
    assign opb_tag_o      = src_tag[1];
    assign opb_data_o     = src_data[1];
    assign opb_ready_o    = src_rdy[1];
endmodule

// File: rtl/alias_renamer_chk.sv
// Property checker for alias_renamer, attached by bind below.
// Observes ports and the map state the table drives.
module alias_renamer_chk #(
    parameter int ARCH_REGS = 8,
    parameter int SLOTS     = 40,
    parameter int LANES     = 4,
    localparam int REG_W    = $clog2(ARCH_REGS),
    localparam int TAG_W    = $clog2(SLOTS)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             flush_i,
    input logic [LANES-1:0]                 ren_valid_i,
    input logic [LANES*REG_W-1:0]           ren_src_a_i,
    input logic [LANES*REG_W-1:0]           ren_dst_i,
    input logic [LANES*TAG_W-1:0]           ren_slot_i,
    input logic                             ret_valid_i,
    input logic [REG_W-1:0]                 ret_arch_i,
    input logic [TAG_W-1:0]                 ret_slot_i,
    input logic [LANES-1:0]                 opa_inflight_o,
    input logic [LANES*TAG_W-1:0]           opa_tag_o,
    input logic [LANES-1:0]                 opa_ready_o,
    input logic [LANES-1:0]                 opb_inflight_o,
    input logic [LANES-1:0]                 opb_ready_o,
    input logic [ARCH_REGS-1:0]             map_inflight,
    input logic [ARCH_REGS-1:0][TAG_W-1:0]  map_slot
);
    logic [LANES-1:0][REG_W-1:0] c_src_a, c_dst;
    logic [LANES-1:0][TAG_W-1:0] c_slot, c_tag_a;
    logic [REG_W-1:0]            last_dst;
    logic [TAG_W-1:0]            last_slot;
    logic                        ret_quiet;

    assign c_src_a   = ren_src_a_i;
    assign c_dst     = ren_dst_i;
    assign c_slot    = ren_slot_i;
    assign c_tag_a   = opa_tag_o;
    assign last_dst  = c_dst[LANES-1];
    assign last_slot = c_slot[LANES-1];
    assign ret_quiet = ret_valid_i && !flush_i && (ren_valid_i == '0) && map_inflight[ret_arch_i];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        AST_ARCH_READY_A: assert property (@(posedge clk) disable iff (!rst_n)
            !opa_inflight_o[l] |-> opa_ready_o[l]); // R3
        AST_ARCH_READY_B: assert property (@(posedge clk) disable iff (!rst_n)
            !opb_inflight_o[l] |-> opb_ready_o[l]); // R3
        if (l > 0) begin : g_fwd
            AST_GROUP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
                (ren_valid_i[l-1] && (c_dst[l-1] == c_src_a[l]))
                |-> (opa_inflight_o[l] && (c_tag_a[l] == c_slot[l-1]) && !opa_ready_o[l])); // R5
        end
    end

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (map_inflight == '0)); // R9

    AST_LAST_LANE_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && ren_valid_i[LANES-1])
        |=> (map_inflight[$past(last_dst)] && (map_slot[$past(last_dst)] == $past(last_slot)))); // R4

    AST_RETIRE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_quiet && (map_slot[ret_arch_i] == ret_slot_i))
        |=> !map_inflight[$past(ret_arch_i)]); // R6

    AST_RETIRE_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_quiet && (map_slot[ret_arch_i] != ret_slot_i))
        |=> (map_inflight[$past(ret_arch_i)] && $stable(map_slot))); // R7
endmodule

bind alias_renamer alias_renamer_chk #(
    .ARCH_REGS (ARCH_REGS),
    .SLOTS     (SLOTS),
    .LANES     (LANES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush_i        (flush_i),
    .ren_valid_i    (ren_valid_i),
    .ren_src_a_i    (ren_src_a_i),
    .ren_dst_i      (ren_dst_i),
    .ren_slot_i     (ren_slot_i),
    .ret_valid_i    (ret_valid_i),
    .ret_arch_i     (ret_arch_i),
    .ret_slot_i     (ret_slot_i),
    .opa_inflight_o (opa_inflight_o),
    .opa_tag_o      (opa_tag_o),
    .opa_ready_o    (opa_ready_o),
    .opb_inflight_o (opb_inflight_o),
    .opb_ready_o    (opb_ready_o),
    .map_inflight   (map_inflight),
    .map_slot       (map_slot)
);

// File: tb/alias_renamer_test.sv
// Bench for alias_renamer: behavioural map model compared every cycle.
module alias_renamer_test;
    localparam int NR = 8;
    localparam int NS = 40;
    localparam int NL = 4;
    localparam int DW = 32;
    localparam int RW = 3;
    localparam int TW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic [NL-1:0]     ren_valid_i = '0;
    logic [NL*RW-1:0]  ren_src_a_i = '0;
    logic [NL*RW-1:0]  ren_src_b_i = '0;
    logic [NL*RW-1:0]  ren_dst_i = '0;
    logic [NL*TW-1:0]  ren_slot_i = '0;
    logic              ret_valid_i = 1'b0;
    logic [RW-1:0]     ret_arch_i = '0;
    logic [TW-1:0]     ret_slot_i = '0;
    logic [NR*DW-1:0]  arf_data_i;
    logic [NS*DW-1:0]  slot_data_i;
    logic [NS-1:0]     slot_done_i = '0;
    logic [NL-1:0]     opa_inflight_o, opa_ready_o, opb_inflight_o, opb_ready_o;
    logic [NL*TW-1:0]  opa_tag_o, opb_tag_o;
    logic [NL*DW-1:0]  opa_data_o, opb_data_o;

    alias_renamer uut (.*);

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Stimulus of the current cycle and the reference map.
    int vld[NL], sa[NL], sb[NL], dd[NL], sl[NL];
    int fl, rv, ra, rs;
    bit m_inf[NR];
    int m_slot[NR];

    function automatic logic [DW-1:0] arf_val(int r);
        return 32'h1000_0000 + r * 32'h11;
    endfunction
    function automatic logic [DW-1:0] slot_val(int s);
        return 32'hA500_0000 + s * 32'h101;
    endfunction

    // Expected outputs for one source, from the requirements.
    task automatic expect_src(input int l, input int r, output bit inf, output int tag,
                              output logic [DW-1:0] dat, output bit rdy, output string req);
        inf = 0; tag = r; dat = arf_val(r); rdy = 1; req = "R1";
        if (m_inf[r]) begin
            inf = 1; tag = m_slot[r]; req = "R2/R3";
            rdy = slot_done_i[tag]; dat = rdy ? slot_val(tag) : '0;
        end
        for (int j = l - 1; j >= 0; j--) begin
            if (vld[j] != 0 && dd[j] == r) begin
                inf = 1; tag = sl[j]; dat = '0; rdy = 0; req = "R5";
                break;
            end
        end
    endtask

    task automatic compare(input string phase);
        for (int l = 0; l < NL; l++) begin
            for (int s = 0; s < 2; s++) begin
                bit ei, er, gi, gr;
                int et, gt;
                logic [DW-1:0] ed, gd;
                string req;
                expect_src(l, (s == 0) ? sa[l] : sb[l], ei, et, ed, er, req);
                gi = (s == 0) ? opa_inflight_o[l] : opb_inflight_o[l];
                gt = (s == 0) ? int'(opa_tag_o[l*TW +: TW]) : int'(opb_tag_o[l*TW +: TW]);
                gd = (s == 0) ? opa_data_o[l*DW +: DW] : opb_data_o[l*DW +: DW];
                gr = (s == 0) ? opa_ready_o[l] : opb_ready_o[l];
                checks++;
                if (gi !== ei || gt != et || gd !== ed || gr !== er) begin
                    failures++;
                    $display("FAIL %s %s lane%0d src%0d got inf=%0b tag=%0d data=%h rdy=%0b exp inf=%0b tag=%0d data=%h rdy=%0b",
                             phase, req, l, s, gi, gt, gd, gr, ei, et, ed, er);
                end
            end
        end
    endtask

    // Drive one cycle at the falling edge, compare, then advance the model.
    task automatic cycle(input string phase);
        for (int l = 0; l < NL; l++) begin
            ren_valid_i[l]           = (vld[l] != 0);
            ren_src_a_i[l*RW +: RW]  = RW'(sa[l]);
            ren_src_b_i[l*RW +: RW]  = RW'(sb[l]);
            ren_dst_i[l*RW +: RW]    = RW'(dd[l]);
            ren_slot_i[l*TW +: TW]   = TW'(sl[l]);
        end
        flush_i = (fl != 0); ret_valid_i = (rv != 0);
        ret_arch_i = RW'(ra); ret_slot_i = TW'(rs);
        #2;
        compare(phase);
        @(posedge clk);
        if (fl != 0) begin
            for (int r = 0; r < NR; r++) m_inf[r] = 0;
        end else begin
            bit wr[NR];
            for (int r = 0; r < NR; r++) wr[r] = 0;
            for (int l = 0; l < NL; l++)
                if (vld[l] != 0) begin m_inf[dd[l]] = 1; m_slot[dd[l]] = sl[l]; wr[dd[l]] = 1; end
            if (rv != 0 && !wr[ra] && m_inf[ra] && m_slot[ra] == rs) m_inf[ra] = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        for (int l = 0; l < NL; l++) begin vld[l] = 0; sa[l] = l; sb[l] = NR - 1 - l; dd[l] = 0; sl[l] = 0; end
        fl = 0; rv = 0; ra = 0; rs = 0;
    endtask

    task automatic set_lane(input int l, input int v, input int a, input int b, input int d, input int s);
        vld[l] = v; sa[l] = a; sb[l] = b; dd[l] = d; sl[l] = s;
    endtask

    initial begin
        for (int r = 0; r < NR; r++) arf_data_i[r*DW +: DW] = arf_val(r);
        for (int s = 0; s < NS; s++) slot_data_i[s*DW +: DW] = slot_val(s);
        for (int r = 0; r < NR; r++) begin m_inf[r] = 0; m_slot[r] = 0; end
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, all sources read the architectural file
        cycle("R1_reset");
        for (int l = 0; l < NL; l++) begin sa[l] = l + 4; sb[l] = l; end
        cycle("R1_reset_b");

        // R4: map reg1 to slot 19 and reg2 to slot 23
        idle_inputs();
        set_lane(0, 1, 0, 0, 1, 19);
        set_lane(1, 1, 3, 4, 2, 23);
        cycle("R4_setup");
        // R5: add reg0 <- reg1 + reg0 (slot 37); sub reg0 <- reg2 - reg0 (slot 38)
        idle_inputs();
        set_lane(0, 1, 1, 0, 0, 37);
        set_lane(1, 1, 2, 0, 0, 38);
        cycle("R5_chain");
        // R4: next group sees reg0 at slot 38; R3: slot 19 completed
        idle_inputs();
        slot_done_i[19] = 1'b1;
        for (int l = 0; l < NL; l++) begin sa[l] = 0; sb[l] = 1; end
        cycle("R4_R3_after_chain");

        // R4/R5: lanes 0 and 2 write reg5, invalid lane 3 writes reg5 too
        idle_inputs();
        set_lane(0, 1, 5, 6, 5, 10);
        set_lane(1, 1, 5, 7, 6, 11);
        set_lane(2, 1, 5, 6, 5, 12);
        set_lane(3, 0, 5, 6, 5, 13);
        cycle("R4_R5_same_dest");
        idle_inputs();
        for (int l = 0; l < NL; l++) begin sa[l] = 5; sb[l] = 6; end
        cycle("R4_R5_invalid_lane");

        // R6: retire slot 19 which still owns reg1
        idle_inputs();
        rv = 1; ra = 1; rs = 19;
        sa[0] = 1;
        cycle("R10_retire_same_cycle");
        idle_inputs();
        sa[0] = 1; sa[1] = 0;
        cycle("R6_retire_match");

        // R7: retire stale slot 37 of reg0 (table holds 38)
        idle_inputs();
        rv = 1; ra = 0; rs = 37;
        cycle("R7_retire_stale_issue");
        idle_inputs();
        sa[0] = 0;
        cycle("R7_retire_stale");

        // R8: retire of reg2's slot 23 while lane 1 remaps reg2 to slot 30
        idle_inputs();
        rv = 1; ra = 2; rs = 23;
        set_lane(1, 1, 3, 3, 2, 30);
        cycle("R8_collide_issue");
        idle_inputs();
        sa[0] = 2;
        cycle("R8_rename_wins");

        // R9/R10: flush with a valid group; outputs that cycle reflect old table
        idle_inputs();
        fl = 1;
        set_lane(0, 1, 0, 2, 4, 33);
        set_lane(1, 1, 4, 5, 7, 34);
        cycle("R10_flush_cycle");
        idle_inputs();
        for (int l = 0; l < NL; l++) begin sa[l] = l; sb[l] = l + 4; end
        cycle("R9_after_flush");

        // Random phase covering all requirements together (R1..R10)
        for (int n = 0; n < 3000; n++) begin
            idle_inputs();
            for (int l = 0; l < NL; l++)
                set_lane(l, ($urandom % 4) != 0, $urandom % NR, $urandom % NR, $urandom % NR, $urandom % NS);
            fl = (($urandom % 40) == 0);
            rv = (($urandom % 2) == 0);
            ra = $urandom % NR;
            rs = (($urandom % 3) != 0) ? m_slot[ra] : int'($urandom % NS);
            for (int s = 0; s < NS; s++) slot_done_i[s] = $urandom % 2;
            cycle("RAND");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule